// File: doc/BRIEF.md
# Synchronous Burst SRAM Command Front End

This block is the control and data front end of a synchronous burst SRAM, with a small behavioural array behind it. On each rising clock edge where the clock enable is active and sleep is low, it samples three chip selects, an advance/load strobe, a write strobe, per-lane byte write enables and an address. From these it decides what kind of cycle the edge is: a new read, a new write, a deselect, a continuation of the current burst, a dummy read, a write abort or a stall. It keeps a 2-bit linear burst counter in the low address bits and drives the data bus through a separate output enable.

Reads are pipelined by one enabled clock. Write data follows its command by one enabled clock and is merged lane by lane. The bus width is set by the number of 9-bit lanes (2, 4 or 8, giving 18, 36 or 72 bits). One active-low byte write enable covers each lane.

Top module: `sbs_front`

## Requirements
- R1: A new cycle starts on an enabled edge with `adv` low. The part is selected only when `cs1_n` is low, `cs2` is high and `cs3_n` is low. If any select is inactive the edge is a deselect: nothing is read or written and `dq_oe` is low after that edge.
- R2: An enabled edge with `adv` high continues the burst. It repeats the read or write type of the last new cycle and ignores the selects, `wr_n` and `addr`. `bw_n` and `oe_n` still apply.
- R3: A continue edge that follows a deselect keeps the part deselected: no read data is driven and no write is performed. After reset the part is in the deselected state.
- R4: Every continue edge adds one to the low two address bits, wrapping modulo 4 from the loaded address. Address bits above bit 1 stay as loaded.
- R5: A read cycle accepted on an enabled edge makes the addressed word available on `dq_o` right after that edge. `dq_oe` goes high then if `oe_n` is low.
- R6: For a write cycle, `dq_i` is stored at the next enabled edge. Lane i (bits 9i+8 down to 9i) is stored only if `bw_n[i]` was low in the write cycle. If every `bw_n` bit is high the cycle is a write abort and the array is unchanged.
- R7: A read or continue-read with `oe_n` high is a dummy read: `dq_oe` stays low, and on a continue the burst counter still advances.
- R8: An edge with `clk_en_n` high is ignored and all state holds. A pipelined read keeps the same data driven, and a write in progress keeps the bus off with its data capture postponed.
- R9: `sleep` high forces `dq_oe` low at once, without waiting for a clock edge. While it is high all other inputs are ignored and the state holds.
- R10: `dq_oe` is low during write cycles even with `oe_n` tied low. `oe_n` acts on `dq_oe` asynchronously.
- R11: While `rst_n` is low and just after it is released, `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high stalls the edge |
| sleep | input | 1 | Asynchronous sleep; forces the bus off and freezes state |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| adv | input | 1 | High continues the burst, low loads a new cycle |
| wr_n | input | 1 | Low selects write on a new cycle |
| bw_n | input | LANES | Active-low write enable per 9-bit lane |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr | input | AW | Word address loaded on a new cycle |
| dq_i | input | 9*LANES | Write data, sampled one enabled edge after its command |
| dq_o | output | 9*LANES | Pipelined read data |
| dq_oe | output | 1 | High when the block drives the data bus |

## Verification
On every clock the embedded properties check the following. The burst counter steps by one and the operation type holds on each continue edge. A stalled edge changes neither the read valid flag nor the read data. An all-lanes-off write leaves nothing pending. A pending write never coincides with a driven bus. A deselect begin clears both the read and the write stage, and the bus is off right after reset. What only the bench scenarios show is that the right data reaches the right place: the lane merge of a partial write, wrap-around reads after a four-beat burst, ignored selects on continue edges, the postponed capture of write data across a stall, and the asynchronous effect of `oe_n` and `sleep` between edges.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
   localparam int LANE_W = 9;

   typedef enum logic [1:0] {
      OP_DESEL = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;
endpackage

// File: rtl/sbs_burst_ctl.sv
module sbs_burst_ctl
   import sbs_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          sel,
   input  logic          adv,
   input  logic          wr_n,
   input  logic [AW-1:0] addr,
   output op_e           cyc_op,
   output logic [AW-1:0] cyc_addr
);
   localparam int HI_W = AW - 2;

   generate
      if (AW < 3) begin : g_aw_bad
         $error("sbs_burst_ctl: AW must be at least 3");
      end
   endgenerate

   op_e             op_q;
   logic [HI_W-1:0] base_q;
   logic [1:0]      cnt_q;
   logic [1:0]      cnt_nxt;

   assign cnt_nxt = cnt_q + 2'd1;

   always_comb begin
      if (adv) begin
         cyc_op   = op_q;
         cyc_addr = {base_q, cnt_nxt};
      end else if (sel) begin
         cyc_op   = wr_n ? OP_READ : OP_WRITE;
         cyc_addr = addr;
      end else begin
         cyc_op   = OP_DESEL;
         cyc_addr = addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_DESEL;
         base_q <= '0;
         cnt_q  <= '0;
      end else if (step) begin
         if (adv) begin
            cnt_q <= cnt_nxt;
         end else begin
            op_q   <= cyc_op;
            base_q <= addr[AW-1:2];
            cnt_q  <= addr[1:0];
         end
      end
   end

   // R4
   burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step && adv |=> (cnt_q == $past(cnt_q) + 2'd1) && $stable(base_q));

   // R2
   cont_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step && adv |=> $stable(op_q));
endmodule

// File: rtl/sbs_wr_stage.sv
module sbs_wr_stage
   import sbs_pkg::*;
#(
   parameter int AW    = 6,
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  op_e              cyc_op,
   input  logic [LANES-1:0] bw_n,
   input  logic [AW-1:0]    cyc_addr,
   output logic             pend,
   output logic [AW-1:0]    pend_addr,
   output logic [LANES-1:0] pend_lanes
);
   logic any_lane;

   assign any_lane = ~&bw_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend       <= 1'b0;
         pend_addr  <= '0;
         pend_lanes <= '0;
      end else if (step) begin
         pend       <= (cyc_op == OP_WRITE) && any_lane;
         pend_addr  <= cyc_addr;
         pend_lanes <= ~bw_n;
      end
   end

   // R6
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step && (&bw_n) |=> !pend);

   // R6
   lanes_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> (pend_lanes != '0));
endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array
   import sbs_pkg::*;
#(
   parameter int AW    = 6,
   parameter int LANES = 2
) (
   input  logic                    clk,
   input  logic                    wr_en,
   input  logic [AW-1:0]           wr_addr,
   input  logic [LANES-1:0]        wr_lanes,
   input  logic [LANE_W*LANES-1:0] wr_data,
   input  logic [AW-1:0]           rd_addr,
   output logic [LANE_W*LANES-1:0] rd_data
);
   localparam int DEPTH = 1 << AW;

   generate
      if (AW > 12) begin : g_depth_bad
         $error("sbs_lane_array: AW too large for the behavioural array");
      end
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] mem [DEPTH];

         always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g]) begin
               mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
         end

         assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
      end
   endgenerate
endmodule

// File: rtl/sbs_front.sv
module sbs_front
   import sbs_pkg::*;
#(
   parameter int AW    = 6,
   parameter int LANES = 2,
   localparam int DW   = LANE_W * LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en_n,
   input  logic             sleep,
   input  logic             cs1_n,
   input  logic             cs2,
   input  logic             cs3_n,
   input  logic             adv,
   input  logic             wr_n,
   input  logic [LANES-1:0] bw_n,
   input  logic             oe_n,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    dq_i,
   output logic [DW-1:0]    dq_o,
   output logic             dq_oe
);
   generate
      if (!(LANES == 2 || LANES == 4 || LANES == 8)) begin : g_lanes_bad
         $error("sbs_front: LANES must be 2, 4 or 8");
      end
   endgenerate

   logic             step;
   logic             sel;
   op_e              cyc_op;
   logic [AW-1:0]    cyc_addr;
   logic             pend;
   logic [AW-1:0]    pend_addr;
   logic [LANES-1:0] pend_lanes;
   logic [DW-1:0]    arr_rd;
   logic             rd_valid_q;
   logic [DW-1:0]    rd_q;

   assign step = !clk_en_n && !sleep;
   assign sel  = !cs1_n && cs2 && !cs3_n;

   sbs_burst_ctl #(.AW(AW)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .sel      (sel),
      .adv      (adv),
      .wr_n     (wr_n),
      .addr     (addr),
      .cyc_op   (cyc_op),
      .cyc_addr (cyc_addr)
   );

   sbs_wr_stage #(.AW(AW), .LANES(LANES)) u_wr (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (step),
      .cyc_op     (cyc_op),
      .bw_n       (bw_n),
      .cyc_addr   (cyc_addr),
      .pend       (pend),
      .pend_addr  (pend_addr),
      .pend_lanes (pend_lanes)
   );

   sbs_lane_array #(.AW(AW), .LANES(LANES)) u_arr (
      .clk      (clk),
      .wr_en    (step && pend),
      .wr_addr  (pend_addr),
      .wr_lanes (pend_lanes),
      .wr_data  (dq_i),
      .rd_addr  (cyc_addr),
      .rd_data  (arr_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_q <= 1'b0;
         rd_q       <= '0;
      end else if (step) begin
         rd_valid_q <= (cyc_op == OP_READ);
         if (cyc_op == OP_READ) begin
            rd_q <= arr_rd;
         end
      end
   end

   assign dq_o  = rd_q;
   assign dq_oe = rd_valid_q && !oe_n && !sleep;

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(rd_valid_q) && $stable(rd_q));

   // R10
   wr_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> !dq_oe);

   // R1
   desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step && !adv && !sel |=> !rd_valid_q && !pend);

   // R11
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !dq_oe && !pend);
endmodule

// File: tb/sbs_front_tb.sv
module sbs_front_tb;
   localparam int AW = 6;
   localparam int LN = 2;
   localparam int DW = 18;
   localparam int NV = 22;

   localparam logic [17:0] J  = 18'h2aaaa;
   localparam logic [17:0] D0 = 18'h01111;
   localparam logic [17:0] D1 = 18'h02222;
   localparam logic [17:0] D2 = 18'h03333;
   localparam logic [17:0] D3 = 18'h04444;
   localparam logic [17:0] D4 = 18'h15555;
   localparam logic [17:0] D5 = 18'h26666;
   localparam logic [17:0] D6 = 18'h3ffff;

   typedef struct packed {
      logic        cke_n, slp, e1n, e2, e3n, adv, wr_n;
      logic [1:0]  bw_n;
      logic        oe_n;
      logic [5:0]  addr;
      logic [17:0] din;
      logic        exp_oe;
   } vec_t;

   //                cke slp e1n e2 e3n adv wr  bw     oe  addr   din exp
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,6'h04,J ,1'b0}, // 0  R1 write begin @4
      '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b00,1'b0,6'h00,D0,1'b0}, // 1  R2 continue, selects ignored
      '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,1'b0,6'h00,D1,1'b0}, // 2  R6
      '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,1'b0,6'h00,D2,1'b0}, // 3  R4
      '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b01,1'b0,6'h00,D3,1'b0}, // 4  R4 wrap, lane1 only
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,6'h10,D4,1'b0}, // 5  R1 deselect cs1_n
      '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,2'b00,1'b0,6'h00,J ,1'b0}, // 6  R3 deselect continue
      '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'b11,1'b0,6'h04,J ,1'b1}, // 7  R5 read begin @4
      '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,2'b00,1'b0,6'h3f,J ,1'b1}, // 8  R2 continue read @5
      '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'b11,1'b0,6'h3f,J ,1'b1}, // 9  R8 stall during read
      '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,6'h00,J ,1'b0}, // 10 R7 dummy read @6
      '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,6'h00,J ,1'b1}, // 11 R7 counter moved: @7
      '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,6'h00,J ,1'b1}, // 12 R4 wrap read @4
      '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,2'b11,1'b0,6'h05,J ,1'b0}, // 13 R9 sleep
      '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,6'h20,J ,1'b1}, // 14 R8 stall keeps data
      '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,6'h08,J ,1'b0}, // 15 R10 write begin @8
      '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'b11,1'b0,6'h00,J ,1'b0}, // 16 R8 stall during write
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b11,1'b0,6'h00,D5,1'b0}, // 17 R1 deselect cs2
      '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'b11,1'b0,6'h08,J ,1'b1}, // 18 R8 read @8
      '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'b11,1'b0,6'h04,J ,1'b0}, // 19 R6 write abort @4
      '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,2'b11,1'b0,6'h00,D6,1'b0}, // 20 R1 deselect cs3_n
      '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'b11,1'b0,6'h04,J ,1'b1}  // 21 R6 @4 unchanged
   };

   localparam string TAG [NV] = '{
      "R1","R2","R6","R4","R4","R1","R3","R5","R2","R8","R7",
      "R7","R4","R9","R8","R10","R8","R1","R8","R6","R1","R6"
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          clk_en_n, sleep, cs1_n, cs2, cs3_n, adv, wr_n, oe_n;
   logic [LN-1:0] bw_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] dq_i, dq_o;
   logic          dq_oe;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   sbs_front #(.AW(AW), .LANES(LN)) u_dut (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sleep(sleep),
      .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .adv(adv), .wr_n(wr_n),
      .bw_n(bw_n), .oe_n(oe_n), .addr(addr), .dq_i(dq_i),
      .dq_o(dq_o), .dq_oe(dq_oe)
   );

   // reference model state (0 deselect, 1 read, 2 write)
   logic [DW-1:0] mref [64];
   int            m_op;
   logic [3:0]    m_base;
   logic [1:0]    m_cnt;
   logic          m_rv;
   logic [DW-1:0] m_rd;
   logic          m_wp;
   logic [5:0]    m_wa;
   logic [1:0]    m_wl;

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_edge(input vec_t v);
      int            op;
      logic [5:0]    a;
      logic [DW-1:0] rv;
      if (v.cke_n || v.slp) return;
      if (v.adv) begin
         m_cnt = m_cnt + 2'd1;
         op    = m_op;
         a     = {m_base, m_cnt};
      end else begin
         op     = (!v.e1n && v.e2 && !v.e3n) ? (v.wr_n ? 1 : 2) : 0;
         m_op   = op;
         m_base = v.addr[5:2];
         m_cnt  = v.addr[1:0];
         a      = v.addr;
      end
      rv = mref[a];
      if (m_wp) begin
         for (int l = 0; l < LN; l++)
            if (m_wl[l]) mref[m_wa][9*l +: 9] = v.din[9*l +: 9];
      end
      m_rv = (op == 1);
      if (op == 1) m_rd = rv;
      m_wp = (op == 2) && (v.bw_n != 2'b11);
      m_wa = a;
      m_wl = ~v.bw_n;
   endtask

   task automatic drive(input vec_t v);
      clk_en_n = v.cke_n; sleep = v.slp; cs1_n = v.e1n; cs2 = v.e2;
      cs3_n = v.e3n; adv = v.adv; wr_n = v.wr_n; bw_n = v.bw_n;
      oe_n = v.oe_n; addr = v.addr; dq_i = v.din;
   endtask

   initial begin
      rst_n = 1'b0;
      drive('{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,2'b11,1'b0,6'h00,18'h0,1'b0});
      m_op = 0; m_base = '0; m_cnt = '0; m_rv = 0; m_rd = '0; m_wp = 0; m_wa = '0; m_wl = '0;
      repeat (3) @(negedge clk);
      chk("R11 reset bus off", {17'b0, dq_oe}, 18'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 idle after release", {17'b0, dq_oe}, 18'h0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i]);
         @(posedge clk);
         model_edge(VEC[i]);
         @(negedge clk);
         chk({TAG[i], " drive state"}, {17'b0, dq_oe}, {17'b0, VEC[i].exp_oe});
         if (VEC[i].exp_oe) chk({TAG[i], " read data"}, dq_o, m_rd);
      end

      // R6: partial write kept lane 0 of D0 and lane 1 of D4, abort changed nothing
      chk("R6 lane merge", dq_o, {D4[17:9], D0[8:0]});
      // R10: oe_n acts between edges
      #0.5 oe_n = 1'b1;
      #0.5 chk("R10 async oe_n off", {17'b0, dq_oe}, 18'h0);
      oe_n = 1'b0;
      #0.5 chk("R10 async oe_n on", {17'b0, dq_oe}, 18'h1);
      // R9: sleep acts between edges
      sleep = 1'b1;
      #0.5 chk("R9 async sleep off", {17'b0, dq_oe}, 18'h0);
      sleep = 1'b0;
      #0.5 chk("R9 wake keeps data", dq_o, {D4[17:9], D0[8:0]});

      // R11/R3: continue right after reset stays deselected
      @(negedge clk);
      rst_n = 1'b0;
      #0.5 chk("R11 async reset off", {17'b0, dq_oe}, 18'h0);
      @(negedge clk);
      rst_n = 1'b1;
      drive('{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,6'h00,J,1'b0});
      @(negedge clk);
      chk("R3 continue after reset", {17'b0, dq_oe}, 18'h0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule